// File: doc/BRIEF.md
# Fan-beam projection operand generator

This block feeds a divider that computes the detector coordinate of every image pixel for one projection angle of a fan-beam reconstruction. For each angle it receives four constants: the cosine and sine of the angle, and the same two values already divided by the source-to-centre distance D. It then produces one (numerator, denominator) pair per pixel of an N×N image. Each pair is the dividend and the divisor of the coordinate quotient. The generator never multiplies: it derives its starting values from the constants with shifts and adds, then walks the image with nested running sums.

The scan is column-major. The outer index x walks the columns. The inner index y walks the rows inside one column. At the start of each column, the column sums take one step. Those sums then seed the row sums, and every row step emits one pair. The output follows a valid/ready handshake. When the consumer stalls, the pair on the outputs and all running sums hold. After the last pair is accepted, the block raises a one-cycle completion pulse and waits for the next start with fresh constants.

All running sums are exact. The numerator carries the same fractional precision as the trigonometric inputs, and the denominator carries the same fractional precision as the ratio inputs. Error appears only in the final truncation of the denominator, and it does not grow with image size.

Top module: `fanbeam_opgen`

## Requirements
- R1: While reset is high and on the first cycle after it falls, `out_valid`, `done` and `busy` are all 0.
- R2: A `start` pulse seen while `busy` is 0 latches `cos_in`, `sin_in`, `cos_d_in` and `sin_d_in`. `busy` is 1 in the next cycle, while `out_valid` is still 0, and the first pair is valid one cycle after that. Input changes after the start edge have no effect on the sequence.
- R3: Let H = N/2, with N the image size. For pixel k = x·N + y, with x = k div N and y = k mod N, `out_num` (signed, 36 bits, 16 fraction bits) equals (x+1−H)·cos + (y+1−H)·sin. Here cos and sin are signed 18-bit inputs with 16 fraction bits. Pairs are accepted in increasing order of k.
- R4: `out_den` is 18 bits with 16 fraction bits. It equals bits [27:10] of the exact value 2^26 + (x+1−H)·sin_d − (y+1−H)·cos_d, in which sin_d and cos_d are signed 18-bit ratio inputs with 26 fraction bits. The result is truncated, never rounded. For any angle with D > N, `out_den` is positive.
- R5: Exactly N·N pairs are accepted per start. In the cycle after the last acceptance, `done` is 1 for one cycle, `busy` is 0 and `out_valid` is 0.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_num` and `out_den` keep their values into the next cycle.
- R7: A `start` pulse while `busy` is 1 is ignored. The running sequence keeps its constants and its pixel order, and still ends after N·N pairs.
- R8: A start given after `done` begins a fresh sequence from pixel 0 with the new constants, with no carry-over from the previous angle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one angle; sampled only while idle |
| cos_in | input | TRIG_W | Cosine of the angle, signed, TRIG_F fraction bits |
| sin_in | input | TRIG_W | Sine of the angle, signed, TRIG_F fraction bits |
| cos_d_in | input | RATIO_W | Cosine divided by D, signed, RATIO_F fraction bits |
| sin_d_in | input | RATIO_W | Sine divided by D, signed, RATIO_F fraction bits |
| busy | output | 1 | An angle is in progress |
| done | output | 1 | One-cycle pulse after the last pair is accepted |
| out_valid | output | 1 | Pair on the outputs is valid |
| out_ready | input | 1 | Consumer accepts the pair this cycle |
| out_num | output | NUM_W | Numerator, signed, TRIG_F fraction bits |
| out_den | output | DEN_W | Denominator, DEN_F fraction bits |

## Verification
The bench builds the generator with IMG_N = 32 and keeps every other format at its default. This makes one angle 1024 pairs long, so several complete angles fit easily within the cycle budget. The seed shift is small, yet every column-to-column reload and the final drain are still exercised. Each pair is compared with a direct evaluation of the pixel formula, so the column seeding, the row stepping and the truncation are all checked at every pixel. These checks run under steady, periodic and long-burst backpressure, with constants of both signs. The shift and counter widths are derived from IMG_N, so the same structure serves at 512 as well.

// File: rtl/fanbeam_opgen_pkg.sv
package fanbeam_opgen_pkg;

  typedef enum logic [1:0] {
    SCAN_IDLE  = 2'd0,
    SCAN_RUN   = 2'd1,
    SCAN_DRAIN = 2'd2
  } scan_state_e;

  // sign-extension helpers are written inline per width; the package holds shared types only

endpackage

// File: rtl/fanbeam_opgen_seed.sv
// Per-angle starting values, formed with shifts and adds only.
module fanbeam_opgen_seed #(
  parameter int IMG_N     = 512,
  parameter int TRIG_W    = 18,
  parameter int RATIO_W   = 18,
  parameter int RATIO_F   = 26,
  parameter int NUM_W     = 36,
  parameter int DEN_ACC_W = 32
) (
  input  logic signed [TRIG_W-1:0]    cos_v,
  input  logic signed [TRIG_W-1:0]    sin_v,
  input  logic signed [RATIO_W-1:0]   cos_d_v,
  input  logic signed [RATIO_W-1:0]   sin_d_v,
  output logic signed [NUM_W-1:0]     num_seed,
  output logic signed [DEN_ACC_W-1:0] den_seed
);

  localparam int SHIFT = $clog2(IMG_N) - 1;

  logic signed [NUM_W-1:0]     cos_x, sin_x, trig_sum;
  logic signed [DEN_ACC_W-1:0] cd_x, sd_x, ratio_diff, unity;

  always_comb begin
    cos_x      = {{(NUM_W-TRIG_W){cos_v[TRIG_W-1]}}, cos_v};
    sin_x      = {{(NUM_W-TRIG_W){sin_v[TRIG_W-1]}}, sin_v};
    trig_sum   = cos_x + sin_x;
    num_seed   = -(trig_sum <<< SHIFT);

    cd_x       = {{(DEN_ACC_W-RATIO_W){cos_d_v[RATIO_W-1]}}, cos_d_v};
    sd_x       = {{(DEN_ACC_W-RATIO_W){sin_d_v[RATIO_W-1]}}, sin_d_v};
    ratio_diff = cd_x - sd_x;
    unity      = DEN_ACC_W'(1) << RATIO_F;
    den_seed   = unity + (ratio_diff <<< SHIFT);
  end

endmodule

// File: rtl/fanbeam_opgen_accum.sv
// One axis of the nested recurrence: a column sum that seeds a row sum.
module fanbeam_opgen_accum #(
  parameter int W = 36
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                step,
  input  logic                col_start,
  input  logic signed [W-1:0] seed,
  input  logic signed [W-1:0] col_inc,
  input  logic signed [W-1:0] row_inc,
  output logic signed [W-1:0] row_val
);

  logic signed [W-1:0] col_val;
  logic signed [W-1:0] col_next;

  assign col_next = col_val + col_inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      col_val <= '0;
      row_val <= '0;
    end else if (load) begin
      col_val <= seed;
    end else if (step) begin
      if (col_start) begin
        col_val <= col_next;
        row_val <= col_next + row_inc;
      end else begin
        row_val <= row_val + row_inc;
      end
    end
  end

  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(row_val));

  // R3
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !col_start) |=> (row_val == $past(row_val) + $past(row_inc)));

endmodule

// File: rtl/fanbeam_opgen_scan.sv
// Pixel counters, handshake and angle sequencing.
module fanbeam_opgen_scan
  import fanbeam_opgen_pkg::*;
#(
  parameter int IMG_N = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic out_ready,
  output logic load,
  output logic step,
  output logic col_start,
  output logic out_valid,
  output logic busy,
  output logic done
);

  localparam int CNT_W = $clog2(IMG_N);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IMG_N - 1);

  scan_state_e      state;
  logic [CNT_W-1:0] col_idx, row_idx;
  logic             last_pix;

  assign busy      = (state != SCAN_IDLE);
  assign load      = start && (state == SCAN_IDLE);
  assign step      = (state == SCAN_RUN) && (!out_valid || out_ready);
  assign col_start = (row_idx == '0);
  assign last_pix  = (col_idx == LAST) && (row_idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SCAN_IDLE;
      col_idx   <= '0;
      row_idx   <= '0;
      out_valid <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SCAN_IDLE: begin
          if (start) begin
            state   <= SCAN_RUN;
            col_idx <= '0;
            row_idx <= '0;
          end
        end
        SCAN_RUN: begin
          if (step) begin
            out_valid <= 1'b1;
            if (last_pix) begin
              state <= SCAN_DRAIN;
            end else if (row_idx == LAST) begin
              row_idx <= '0;
              col_idx <= col_idx + 1'b1;
            end else begin
              row_idx <= row_idx + 1'b1;
            end
          end
        end
        SCAN_DRAIN: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            done      <= 1'b1;
            state     <= SCAN_IDLE;
          end
        end
        default: state <= SCAN_IDLE;
      endcase
    end
  end

  // R2
  start_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !out_valid));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!out_valid && !busy));

  // R6
  stall_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid);

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (start && state == SCAN_RUN) |=> busy);

endmodule

// File: rtl/fanbeam_opgen.sv
module fanbeam_opgen #(
  parameter int IMG_N     = 512,
  parameter int TRIG_W    = 18,
  parameter int TRIG_F    = 16,
  parameter int RATIO_W   = 18,
  parameter int RATIO_F   = 26,
  parameter int NUM_W     = 36,
  parameter int DEN_W     = 18,
  parameter int DEN_F     = 16,
  parameter int DEN_ACC_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic signed [TRIG_W-1:0]  cos_in,
  input  logic signed [TRIG_W-1:0]  sin_in,
  input  logic signed [RATIO_W-1:0] cos_d_in,
  input  logic signed [RATIO_W-1:0] sin_d_in,
  output logic                      busy,
  output logic                      done,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [NUM_W-1:0]          out_num,
  output logic [DEN_W-1:0]          out_den
);

  localparam int DEN_DROP = RATIO_F - DEN_F;
  localparam int TRIG_FRAC = TRIG_F;

  logic signed [TRIG_W-1:0]    cos_q, sin_q;
  logic signed [RATIO_W-1:0]   cos_d_q, sin_d_q;
  logic signed [NUM_W-1:0]     num_seed, num_row, num_col_inc, num_row_inc;
  logic signed [DEN_ACC_W-1:0] den_seed, den_row, den_col_inc, den_row_inc;
  logic load, step, col_start;

  // constants for the current angle; held for the whole scan
  always_ff @(posedge clk) begin
    if (rst) begin
      cos_q   <= '0;
      sin_q   <= '0;
      cos_d_q <= '0;
      sin_d_q <= '0;
    end else if (load) begin
      cos_q   <= cos_in;
      sin_q   <= sin_in;
      cos_d_q <= cos_d_in;
      sin_d_q <= sin_d_in;
    end
  end

  fanbeam_opgen_seed #(
    .IMG_N(IMG_N), .TRIG_W(TRIG_W), .RATIO_W(RATIO_W), .RATIO_F(RATIO_F),
    .NUM_W(NUM_W), .DEN_ACC_W(DEN_ACC_W)
  ) u_seed (
    .cos_v(cos_in), .sin_v(sin_in), .cos_d_v(cos_d_in), .sin_d_v(sin_d_in),
    .num_seed(num_seed), .den_seed(den_seed)
  );

  fanbeam_opgen_scan #(.IMG_N(IMG_N)) u_scan (
    .clk(clk), .rst(rst), .start(start), .out_ready(out_ready),
    .load(load), .step(step), .col_start(col_start),
    .out_valid(out_valid), .busy(busy), .done(done)
  );

  assign num_col_inc = {{(NUM_W-TRIG_W){cos_q[TRIG_W-1]}}, cos_q};
  assign num_row_inc = {{(NUM_W-TRIG_W){sin_q[TRIG_W-1]}}, sin_q};
  assign den_col_inc = {{(DEN_ACC_W-RATIO_W){sin_d_q[RATIO_W-1]}}, sin_d_q};
  assign den_row_inc = -{{(DEN_ACC_W-RATIO_W){cos_d_q[RATIO_W-1]}}, cos_d_q};

  fanbeam_opgen_accum #(.W(NUM_W)) u_num (
    .clk(clk), .rst(rst), .load(load), .step(step), .col_start(col_start),
    .seed(num_seed), .col_inc(num_col_inc), .row_inc(num_row_inc),
    .row_val(num_row)
  );

  fanbeam_opgen_accum #(.W(DEN_ACC_W)) u_den (
    .clk(clk), .rst(rst), .load(load), .step(step), .col_start(col_start),
    .seed(den_seed), .col_inc(den_col_inc), .row_inc(den_row_inc),
    .row_val(den_row)
  );

  assign out_num = num_row;
  assign out_den = den_row[DEN_DROP +: DEN_W];

  // R4
  den_positive_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_den[DEN_W-1]);

  // R6
  stall_data_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> ($stable(out_num) && $stable(out_den)));

  // R2
  const_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> ($stable(cos_q) || $past(load)));

  initial begin
    fmt_chk: assert (DEN_F <= RATIO_F && TRIG_FRAC <= NUM_W && (1 << $clog2(IMG_N)) == IMG_N);
  end

endmodule

// File: tb/tb_fanbeam_opgen.sv
module tb_fanbeam_opgen;

  localparam int N  = 32;
  localparam int H  = N / 2;
  localparam int RF = 26;
  localparam int DF = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic signed [17:0] cos_in = '0, sin_in = '0, cos_d_in = '0, sin_d_in = '0;
  logic busy, done, out_valid;
  logic out_ready = 1'b0;
  logic [35:0] out_num;
  logic [17:0] out_den;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  fanbeam_opgen #(.IMG_N(N)) dut (
    .clk(clk), .rst(rst), .start(start),
    .cos_in(cos_in), .sin_in(sin_in), .cos_d_in(cos_d_in), .sin_d_in(sin_d_in),
    .busy(busy), .done(done), .out_valid(out_valid), .out_ready(out_ready),
    .out_num(out_num), .out_den(out_den)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic bit ready_pat(input int mode, input int cyc);
    case (mode)
      0: return 1'b1;
      1: return (cyc % 3) != 0;
      default: return ((cyc / 7) % 2) == 0;
    endcase
  endfunction

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1 out_valid in reset", out_valid, 0);
    chk(!done, "R1 done in reset", done, 0);
    chk(!busy, "R1 busy in reset", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !done && !busy, "R1 after reset", {out_valid, done, busy}, 0);
  endtask

  // one full angle; poke>0 gives a start pulse with garbage constants mid-run
  task automatic run_angle(input string name, input int c, input int s, input int cd,
                           input int sd, input int mode, input int poke);
    int idx = 0, cyc = 0, num_bad = 0, den_bad = 0, stall_bad = 0, stalls = 0;
    longint bad_a = 0, bad_e = 0, dbad_a = 0, dbad_e = 0;
    bit seen_done = 0, pend = 0;
    logic [35:0] hn;
    logic [17:0] hd;
    @(negedge clk);
    cos_in = 18'(c); sin_in = 18'(s); cos_d_in = 18'(cd); sin_d_in = 18'(sd);
    start = 1'b1;
    out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    // R2: constants already latched; scramble inputs
    cos_in = 18'sd777; sin_in = -18'sd999; cos_d_in = 18'sd12345; sin_d_in = -18'sd4321;
    chk(busy && !out_valid, {"R2 busy without valid ", name}, {busy, out_valid}, 2);
    while (!seen_done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (pend) begin
        if (!out_valid || out_num != hn || out_den != hd) stall_bad++;
        pend = 0;
      end
      if (cyc == 1) chk(out_valid, {"R2 first pair valid ", name}, out_valid, 1);
      start = (poke > 0 && cyc == poke);
      out_ready = ready_pat(mode, cyc);
      if (out_valid) begin
        if (out_ready) begin
          longint x = idx / N, y = idx % N;
          longint en = (x + 1 - H) * c + (y + 1 - H) * s;
          longint er = (longint'(1) <<< RF) + (x + 1 - H) * sd - (y + 1 - H) * cd;
          longint ed = (er >>> (RF - DF)) & 64'h3FFFF;
          longint an = $signed(out_num);
          if (an != en) begin if (num_bad == 0) begin bad_a = an; bad_e = en; end num_bad++; end
          if (longint'(out_den) != ed) begin
            if (den_bad == 0) begin dbad_a = out_den; dbad_e = ed; end
            den_bad++;
          end
          idx++;
        end else begin
          hn = out_num; hd = out_den; pend = 1; stalls++;
        end
      end
      if (done) seen_done = 1;
    end
    start = 1'b0;
    out_ready = 1'b0;
    chk(num_bad == 0, {"R3 numerator ", name}, bad_a, bad_e);
    chk(den_bad == 0, {"R4 denominator ", name}, dbad_a, dbad_e);
    chk(seen_done && idx == N * N, {"R5 pair count ", name}, idx, N * N);
    if (mode != 0) chk(stalls > 0 && stall_bad == 0, {"R6 stall hold ", name}, stall_bad, 0);
    if (poke > 0) chk(idx == N * N && num_bad == 0, {"R7 start ignored ", name}, idx, N * N);
    @(negedge clk);
    chk(!done && !busy && !out_valid, {"R5 done one cycle ", name}, {done, busy, out_valid}, 0);
  endtask

  initial begin
    test_reset();
    run_angle("steady", 52429, 39322, 89478, 67109, 0, 0);
    run_angle("periodic stall", -39322, 52429, -67109, 89478, 1, 0);
    run_angle("burst stall + restart poke", 65536, 0, 111848, 0, 2, 40);
    // R8: fresh angle right after done, different signs
    run_angle("R8 next angle", -46341, -46341, -79088, -79088, 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule